// File: doc/BRIEF.md
# Byte-Wide Interrupt Enable and Priority Register

This block is a single 8-bit control register that sits on a simple select/write bus. Some of its bits enable hardware interrupt sources: two timer lines and one device line. Other bits raise software interrupts directly. The lowest bit is a master enable. From the register contents and the incoming lines, the block computes a 4-bit interrupt priority level for the processor. Level 0 means no interrupt.

An asynchronous memory-error pulse is captured into a sticky flag. The flag drives the highest level, 15, and it ignores the master enable while set. Software can release it in only one way: by writing the register with the master enable bit at 0. Software requests are plain register bits, so they stay asserted until software writes them off.

The priority output is combinational from the register, the sticky flag and the interrupt lines. A write therefore shows on the level right after the clock edge that stores it.

Top module: `irq_enable_byte`

## Requirements
- R1: After reset the register reads 0x00, the memory-error flag is clear and `ipl` is 0.
- R2: A clock edge with `sel` and `wr_en` both 1 stores `wr_data` in the register, except bit 6, which always reads 0. While `sel` is 1, `rd_data` shows the stored byte; while `sel` is 0, `rd_data` is 0x00.
- R3: A clock edge with `sel` or `wr_en` at 0 leaves the register unchanged.
- R4: When bit 0 is 1, three hardware lines each raise a level when their enable bit is 1. `tmr1_irq` with bit 7 raises level 14. `tmr0_irq` with bit 5 raises level 10. `dev_irq` with bit 4 raises level 8.
- R5: When bit 0 is 1, register bits 3, 2 and 1 request software levels 6, 4 and 1, whatever the interrupt lines do.
- R6: While bit 0 is 0 and the memory-error flag is clear, `ipl` is 0 for every line state and every value of bits 7 to 1.
- R7: `ipl` is the highest active level among 15, 14, 10, 8, 6, 4 and 1, or 0 when none is active.
- R8: `mem_err` high at a clock edge sets the memory-error flag, provided bit 0 was 1 before that edge. The flag makes `ipl` 15 after that edge. It stays set after the pulse ends and across writes that keep bit 0 at 1.
- R9: A `mem_err` pulse at an edge where bit 0 was 0 before the edge leaves the flag clear. This holds even when the same edge writes bit 0 to 1.
- R10: A write that stores bit 0 as 0 clears the memory-error flag at that edge. This holds even when `mem_err` is high at the same edge.
- R11: The hardware never changes the software request bits. They hold through activity on all interrupt lines until a write changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe, qualified by sel |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register contents while selected, else 0 |
| tmr0_irq | input | 1 | Counter 0 interrupt line (level 10) |
| tmr1_irq | input | 1 | Counter 1 interrupt line (level 14) |
| dev_irq | input | 1 | Device interrupt line (level 8) |
| mem_err | input | 1 | Asynchronous memory-error pulse, sampled on clk |
| ipl | output | 4 | Interrupt priority level to the processor |

## Verification
The hardest situations to reach are the ones where the memory-error pulse and a write land on the same edge. One case is a pulse arriving in the very cycle that clears bit 0. The other is a pulse arriving in the cycle that first sets bit 0. The outcome in each case depends on which enable value the capture uses, the one before the edge or the one after. The bench places the pulse and the write strobe in the same low clock phase so that one rising edge samples both. It then reads the level after that edge. Around these races, every register value is swept against every combination of the three hardware lines, and each resulting level is compared with a priority computed in the bench.

// File: rtl/iebyte_pkg.sv
package iebyte_pkg;
  localparam int REG_W  = 8;
  localparam int LVL_W  = 4;
  localparam int NLVL   = 1 << LVL_W;

  // bit positions inside the byte
  localparam int B_EN14 = 7;
  localparam int B_RSVD = 6;
  localparam int B_EN10 = 5;
  localparam int B_EN8  = 4;
  localparam int B_SW6  = 3;
  localparam int B_SW4  = 2;
  localparam int B_SW1  = 1;
  localparam int B_GLB  = 0;

  // levels each source drives
  localparam int L_MERR = NLVL - 1;
  localparam int L_TMR1 = 14;
  localparam int L_TMR0 = 10;
  localparam int L_DEV  = 8;
  localparam int L_SW6  = 6;
  localparam int L_SW4  = 4;
  localparam int L_SW1  = 1;

  localparam logic [REG_W-1:0] WR_MASK = ~(REG_W'(1) << B_RSVD);

  // index of the highest set bit, 0 when none
  function automatic logic [LVL_W-1:0] top_level(input logic [NLVL-1:0] act);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 1; i < NLVL; i++)
      if (act[i]) r = LVL_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/iebyte_store.sv
module iebyte_store
  import iebyte_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [REG_W-1:0] wr_data,
  input  logic             mem_err,
  output logic [REG_W-1:0] ctl_q,
  output logic             merr_q,
  output logic             clr_fire,
  output logic             set_fire
);
  // a write that takes the master enable low releases the flag
  assign clr_fire = wr_fire && !wr_data[B_GLB];
  // capture uses the enable held before the edge
  assign set_fire = mem_err && ctl_q[B_GLB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      merr_q <= 1'b0;
    end else begin
      if (wr_fire) ctl_q <= wr_data & WR_MASK;
      if (clr_fire)      merr_q <= 1'b0;
      else if (set_fire) merr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/iebyte_prio.sv
module iebyte_prio
  import iebyte_pkg::*;
(
  input  logic [REG_W-1:0] ctl_q,
  input  logic             merr_q,
  input  logic             tmr0_irq,
  input  logic             tmr1_irq,
  input  logic             dev_irq,
  output logic [NLVL-1:0]  act,
  output logic [LVL_W-1:0] ipl
);
  logic glb;
  assign glb = ctl_q[B_GLB];

  always_comb begin
    act = '0;
    act[L_MERR] = merr_q;
    act[L_TMR1] = glb && ctl_q[B_EN14] && tmr1_irq;
    act[L_TMR0] = glb && ctl_q[B_EN10] && tmr0_irq;
    act[L_DEV]  = glb && ctl_q[B_EN8]  && dev_irq;
    act[L_SW6]  = glb && ctl_q[B_SW6];
    act[L_SW4]  = glb && ctl_q[B_SW4];
    act[L_SW1]  = glb && ctl_q[B_SW1];
  end

  assign ipl = top_level(act);
endmodule

// File: rtl/irq_enable_byte.sv
module irq_enable_byte
  import iebyte_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             tmr0_irq,
  input  logic             tmr1_irq,
  input  logic             dev_irq,
  input  logic             mem_err,
  output logic [LVL_W-1:0] ipl
);
  logic             wr_fire;
  logic [REG_W-1:0] ctl_q;
  logic             merr_q;
  logic             clr_fire;
  logic             set_fire;
  logic [NLVL-1:0]  act;

  assign wr_fire = sel && wr_en;
  assign rd_data = sel ? ctl_q : '0;

  iebyte_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .wr_data  (wr_data),
    .mem_err  (mem_err),
    .ctl_q    (ctl_q),
    .merr_q   (merr_q),
    .clr_fire (clr_fire),
    .set_fire (set_fire)
  );

  iebyte_prio u_prio (
    .ctl_q    (ctl_q),
    .merr_q   (merr_q),
    .tmr0_irq (tmr0_irq),
    .tmr1_irq (tmr1_irq),
    .dev_irq  (dev_irq),
    .act      (act),
    .ipl      (ipl)
  );
endmodule

// File: rtl/iebyte_chk.sv
module iebyte_chk
  import iebyte_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] ctl_q,
  input logic             merr_q,
  input logic             mem_err,
  input logic [LVL_W-1:0] ipl
);
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[B_RSVD] == 1'b0);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr_en) |=> $stable(ctl_q));

  // R6
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[B_GLB] && !merr_q) |-> ipl == '0);

  // R8
  merr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merr_q |-> ipl == LVL_W'(L_MERR));

  // R8
  merr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (merr_q && !(sel && wr_en && !wr_data[B_GLB])) |=> merr_q);

  // R9
  merr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!merr_q && !ctl_q[B_GLB]) |=> !merr_q);

  // R10
  merr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && !wr_data[B_GLB]) |=> !merr_q);
endmodule

bind irq_enable_byte iebyte_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel     (sel),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .ctl_q   (ctl_q),
  .merr_q  (merr_q),
  .mem_err (mem_err),
  .ipl     (ipl)
);

// File: tb/tb_irq_enable_byte.sv
`timescale 1ns/1ps
module tb_irq_enable_byte;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tmr0_irq = 1'b0, tmr1_irq = 1'b0, dev_irq = 1'b0, mem_err = 1'b0;
  logic [3:0] ipl;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  irq_enable_byte dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tmr0_irq(tmr0_irq), .tmr1_irq(tmr1_irq),
    .dev_irq(dev_irq), .mem_err(mem_err), .ipl(ipl)
  );

  // expected level from requirements R4-R7, written as an explicit chain
  function automatic logic [3:0] want_ipl(input logic [7:0] r, input logic merr,
                                          input logic t0, input logic t1, input logic dv);
    if (merr) return 4'd15;
    if (r[0] == 1'b0) return 4'd0;
    if (r[7] && t1) return 4'd14;
    if (r[5] && t0) return 4'd10;
    if (r[4] && dv) return 4'd8;
    if (r[3]) return 4'd6;
    if (r[2]) return 4'd4;
    if (r[1]) return 4'd1;
    return 4'd0;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] exp);
    @(negedge clk);
    sel = 1'b1;
    #1 check(req, rd_data, exp);
    sel = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    mem_err = 1'b1;
    @(negedge clk);
    mem_err = 1'b0;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ipl", {4'd0, ipl}, 8'd0);
    sel = 1'b1; #1 check("R1 rd", rd_data, 8'h00); sel = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R2 unselected read", rd_data, 8'h00);

    // sweep every byte against every line state: R2 R4 R5 R6 R7
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      rd_check("R2 readback", 8'(v) & 8'hBF);
      for (int h = 0; h < 8; h++) begin
        tmr0_irq = h[0]; tmr1_irq = h[1]; dev_irq = h[2];
        #1 check(v[0] ? "R7 level" : "R6 masked", {4'd0, ipl},
                 {4'd0, want_ipl(8'(v), 1'b0, h[0], h[1], h[2])});
        @(negedge clk);
      end
    end
    tmr0_irq = 1'b0; tmr1_irq = 1'b0; dev_irq = 1'b0;

    // R3 writes without select or strobe
    wr(8'h0E);
    @(negedge clk); sel = 1'b0; wr_en = 1'b1; wr_data = 8'hF1;
    @(negedge clk); sel = 1'b1; wr_en = 1'b0;
    @(negedge clk); sel = 1'b0;
    rd_check("R3 ignored write", 8'h0E);

    // R11 software bits survive line activity
    wr(8'h0F);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      tmr0_irq = k[0]; tmr1_irq = k[1]; dev_irq = k[2];
    end
    tmr0_irq = 1'b0; tmr1_irq = 1'b0; dev_irq = 1'b0;
    rd_check("R11 sw bits held", 8'h0F);
    #1 check("R11 level", {4'd0, ipl}, 8'd6);

    // R8 capture and stickiness
    wr(8'h01);
    pulse();
    #1 check("R8 set", {4'd0, ipl}, 8'd15);
    repeat (5) @(negedge clk);
    #1 check("R8 sticky", {4'd0, ipl}, 8'd15);
    wr(8'hB3);
    #1 check("R8 survives write", {4'd0, ipl}, 8'd15);
    // R10 clear by dropping enable
    wr(8'hB2);
    #1 check("R10 cleared", {4'd0, ipl}, 8'd0);
    wr(8'h01);
    #1 check("R10 stays clear", {4'd0, ipl}, 8'd0);

    // R9 pulse while disabled
    wr(8'h00);
    pulse();
    wr(8'h01);
    #1 check("R9 disabled pulse", {4'd0, ipl}, 8'd0);

    // R9 pulse on the edge that enables
    wr(8'h00);
    @(negedge clk); sel = 1'b1; wr_en = 1'b1; wr_data = 8'h01; mem_err = 1'b1;
    @(negedge clk); sel = 1'b0; wr_en = 1'b0; mem_err = 1'b0;
    #1 check("R9 same-edge enable", {4'd0, ipl}, 8'd0);

    // R10 pulse on the edge that clears
    pulse();
    #1 check("R8 set again", {4'd0, ipl}, 8'd15);
    @(negedge clk); sel = 1'b1; wr_en = 1'b1; wr_data = 8'h00; mem_err = 1'b1;
    @(negedge clk); sel = 1'b0; wr_en = 1'b0; mem_err = 1'b0;
    #1 check("R10 clear wins", {4'd0, ipl}, 8'd0);
    wr(8'h01);
    #1 check("R10 no late set", {4'd0, ipl}, 8'd0);

    // R1 reset clears flag and register
    pulse();
    @(negedge clk); rst_n = 1'b0;
    #1 check("R1 reset ipl", {4'd0, ipl}, 8'd0);
    sel = 1'b1; #1 check("R1 reset rd", rd_data, 8'h00); sel = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule